// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative table that turns an effective address into a real address for a load/store pipeline. Each of its entries pairs a searchable tag with a data word. The tag holds an effective page number, a two-bit page-size code and one valid bit for each hardware thread. The data word holds a real page number and a small attribute field. Entries of 4 KB, 64 KB and 64 MB pages can sit in the table together, and every lookup compares against all of them in parallel. A lookup is qualified by the valid bit of the requesting thread.

The associative search and the read of the matching data word both take place in the cycle the lookup is presented. The translated address, the attribute bits and the hit, miss and multi-hit flags are captured in a register. They are presented one cycle later to the stage that compares the translation against a cache directory. Software-side maintenance uses two ports. A write port loads a whole entry by index. An invalidate port clears the thread valid bits of one indexed entry, or of every entry at once. Miss handling and the choice of victim entry belong to the surrounding logic.

Top module: `xlat_buf`

## Requirements
- R1: While `rst` is high, and in the first result cycle after it, every output is zero, and every entry is invalid. A lookup made after reset and before any write reports a miss.
- R2: A lookup presented with `lk_valid` high at one rising edge has its result on the outputs after that edge, with `rs_valid` high. Back-to-back lookups produce back-to-back results.
- R3: Page-size code 00 means 4 KB and ignores effective-address bits [11:0]. Code 01 means 64 KB and ignores bits [15:0]. Code 10 means 64 MB and ignores bits [25:0]. Every effective-address bit above the ignored range must equal the entry's page number (`wr_epn` holds EA bits [63:12]). An entry with code 11 never matches.
- R4: An entry matches only when bit `lk_tid` of its thread-valid field is set. Bit 0 belongs to thread 0 and bit 1 to thread 1.
- R5: On a single hit, `rs_ra` takes its bits from position 12 upward from the entry's real page number (`wr_rpn` holds RA bits [47:12]) above the page's offset width. Below that width it takes the looked-up effective address's own bits. The offset width is 12, 16 or 26 bits, set by the page size.
- R6: When no entry matches, `rs_miss` is high, `rs_hit` is low, and `rs_ra` and `rs_attr` are zero. On any match, `rs_hit` is high and `rs_miss` is low.
- R7: When two or more entries match, both `rs_multi` and `rs_hit` are high, and `rs_ra` and `rs_attr` are zero.
- R8: A lookup presented in the same cycle as a write sees the table as it stood before the write. The written contents are seen from the next cycle on.
- R9: `inv_en` clears every thread valid bit of entry `inv_idx`. If a write to the same index occurs in the same cycle, the invalidate wins and the entry stays invalid.
- R10: `inv_all` clears every entry's thread valid bits and overrides any write in the same cycle.
- R11: On a single hit, `rs_attr` equals the attribute bits last written to the matching entry.
- R12: In a result cycle with no lookup behind it, `rs_valid`, `rs_hit`, `rs_miss`, `rs_multi`, `rs_ra` and `rs_attr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_tid | input | 1 | Requesting hardware thread |
| lk_ea | input | 64 | Effective address to translate |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 7 | Entry index to load |
| wr_epn | input | 52 | Effective page number (EA bits 63:12) |
| wr_size | input | 2 | Page-size code |
| wr_tv | input | 2 | Per-thread valid bits |
| wr_rpn | input | 36 | Real page number (RA bits 47:12) |
| wr_attr | input | 8 | Attribute bits |
| inv_en | input | 1 | Invalidate one entry |
| inv_idx | input | 7 | Entry index to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | At least one entry matched |
| rs_miss | output | 1 | No entry matched |
| rs_multi | output | 1 | More than one entry matched |
| rs_ra | output | 48 | Translated real address |
| rs_attr | output | 8 | Attribute bits of the matching entry |

## Verification
Several properties hold on every cycle and are checked continuously. Hit and miss are exclusive on a valid result, and multi-hit implies hit. A miss carries zero data, and an idle cycle carries nothing. Each lookup yields a result one cycle later. A single hit passes the low twelve address bits through unchanged. After either form of invalidate, the affected valid bits read as zero. Other behaviours can only be shown by the bench's scenarios: whether the right bits are ignored for each page size, the thread qualification, the splice point of the real address, old-contents behaviour when a write and a lookup coincide, and invalidate taking priority over a same-index write. The bench shows each of these against its own model of the table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned EA_W    = 64;
    localparam int unsigned RA_W    = 48;
    localparam int unsigned ATTR_W  = 8;
    localparam int unsigned PG_BITS = 12;
    localparam int unsigned EPN_W   = EA_W - PG_BITS;
    localparam int unsigned RPN_W   = RA_W - PG_BITS;

    localparam int unsigned SH_4K   = 12;
    localparam int unsigned SH_64K  = 16;
    localparam int unsigned SH_64M  = 26;

    typedef enum logic [1:0] {
        PG_4K   = 2'b00,
        PG_64K  = 2'b01,
        PG_64M  = 2'b10,
        PG_RSVD = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic [EPN_W-1:0] epn;
        pg_size_e         size;
    } tag_t;

    typedef struct packed {
        logic [RPN_W-1:0]  rpn;
        logic [ATTR_W-1:0] attr;
    } pte_t;

    // Number of low address bits that form the in-page offset.
    function automatic int unsigned pg_shift(pg_size_e s);
        case (s)
            PG_64K:  return SH_64K;
            PG_64M:  return SH_64M;
            default: return SH_4K;
        endcase
    endfunction

    // Page-number bits excluded from the compare for a given size.
    function automatic logic [EPN_W-1:0] epn_ignore(pg_size_e s);
        logic [63:0] m;
        m = (64'd1 << (pg_shift(s) - PG_BITS)) - 64'd1;
        return m[EPN_W-1:0];
    endfunction

    // Real-address bits taken from the effective address.
    function automatic logic [RA_W-1:0] ra_offset_mask(pg_size_e s);
        logic [63:0] m;
        m = (64'd1 << pg_shift(s)) - 64'd1;
        return m[RA_W-1:0];
    endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned THREADS = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [EPN_W-1:0]          lk_epn,
    input  logic [TID_W-1:0]          lk_tid,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tag_t                      wr_tag,
    input  logic [THREADS-1:0]        wr_tv,
    input  logic                      inv_en,
    input  logic [IDX_W-1:0]          inv_idx,
    input  logic                      inv_all,
    output logic [ENTRIES-1:0]        match,
    output pg_size_e [ENTRIES-1:0]    sizes
);

    tag_t               tags [ENTRIES];
    logic [THREADS-1:0] tv   [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i] <= '0;
                tv[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all || (inv_en && inv_idx == IDX_W'(i))) begin
                    tv[i] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    tags[i] <= wr_tag;
                    tv[i]   <= wr_tv;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_line
            logic [EPN_W-1:0] diff;
            assign diff     = (tags[g].epn ^ lk_epn) & ~epn_ignore(tags[g].size);
            assign match[g] = tv[g][lk_tid] && (tags[g].size != PG_RSVD) && (diff == '0);
            assign sizes[g] = tags[g].size;
        end
    endgenerate

    logic any_tv;
    always_comb begin
        any_tv = 1'b0;
        for (int i = 0; i < ENTRIES; i++) any_tv = any_tv | (|tv[i]);
    end

    assert_inv_all_R10: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> !any_tv);

    assert_inv_one_R9: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> (tv[$past(inv_idx)] == '0));

endmodule

// File: rtl/xlat_ram.sv
module xlat_ram
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  pte_t               wr_pte,
    input  logic [ENTRIES-1:0] hit_line,
    output pte_t               rd_pte
);

    pte_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_pte;
        end
    end

    // Hit lines drive the read directly: a wired-OR of selected rows.
    always_comb begin
        rd_pte = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_line[i]) rd_pte = rd_pte | mem[i];
        end
    end

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned THREADS = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [TID_W-1:0]     lk_tid,
    input  logic [EA_W-1:0]      lk_ea,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [EPN_W-1:0]     wr_epn,
    input  logic [1:0]           wr_size,
    input  logic [THREADS-1:0]   wr_tv,
    input  logic [RPN_W-1:0]     wr_rpn,
    input  logic [ATTR_W-1:0]    wr_attr,
    input  logic                 inv_en,
    input  logic [IDX_W-1:0]     inv_idx,
    input  logic                 inv_all,
    output logic                 rs_valid,
    output logic                 rs_hit,
    output logic                 rs_miss,
    output logic                 rs_multi,
    output logic [RA_W-1:0]      rs_ra,
    output logic [ATTR_W-1:0]    rs_attr
);

    logic [ENTRIES-1:0]     match;
    pg_size_e [ENTRIES-1:0] sizes;
    tag_t                   wr_tag;
    pte_t                   wr_pte;
    pte_t                   rd_pte;

    assign wr_tag = '{epn: wr_epn, size: pg_size_e'(wr_size)};
    assign wr_pte = '{rpn: wr_rpn, attr: wr_attr};

    xlat_cam #(.ENTRIES(ENTRIES), .THREADS(THREADS)) u_cam (
        .clk     (clk),
        .rst     (rst),
        .lk_epn  (lk_ea[EA_W-1:PG_BITS]),
        .lk_tid  (lk_tid),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_tv   (wr_tv),
        .inv_en  (inv_en),
        .inv_idx (inv_idx),
        .inv_all (inv_all),
        .match   (match),
        .sizes   (sizes)
    );

    xlat_ram #(.ENTRIES(ENTRIES)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_pte   (wr_pte),
        .hit_line (match),
        .rd_pte   (rd_pte)
    );

    // Second half of the cycle: splice offset and page number.
    logic            any_hit, many_hit;
    logic [RA_W-1:0] off_mask, ra_n;
    logic [RA_W-1:0] page_ra;

    assign any_hit  = |match;
    assign many_hit = |(match & (match - ENTRIES'(1)));
    assign page_ra  = {rd_pte.rpn, {PG_BITS{1'b0}}};

    always_comb begin
        off_mask = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) off_mask = off_mask | ra_offset_mask(sizes[i]);
        end
    end

    assign ra_n = (page_ra & ~off_mask) | (lk_ea[RA_W-1:0] & off_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_miss  <= 1'b0;
            rs_multi <= 1'b0;
            rs_ra    <= '0;
            rs_attr  <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && any_hit;
            rs_miss  <= lk_valid && !any_hit;
            rs_multi <= lk_valid && many_hit;
            rs_ra    <= (lk_valid && !many_hit) ? ra_n : '0;
            rs_attr  <= (lk_valid && !many_hit) ? rd_pte.attr : '0;
        end
    end

    assert_stage_lat_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rs_valid);

    assert_hit_xor_miss_R6: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> (rs_hit != rs_miss));

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rs_miss |-> (rs_ra == '0 && rs_attr == '0));

    assert_multi_hit_R7: assert property (@(posedge clk) disable iff (rst)
        rs_multi |-> (rs_hit && rs_ra == '0 && rs_attr == '0));

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (rs_hit && !rs_multi) |-> (rs_ra[PG_BITS-1:0] == $past(lk_ea[PG_BITS-1:0])));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |-> !(rs_hit || rs_miss || rs_multi));

endmodule

// File: tb/tb_xlat_buf.sv
`timescale 1ns/1ps
module tb_xlat_buf;
    import xlat_pkg::*;

    localparam int N = 128;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              lk_valid;
    logic [0:0]        lk_tid;
    logic [EA_W-1:0]   lk_ea;
    logic              wr_en;
    logic [6:0]        wr_idx;
    logic [EPN_W-1:0]  wr_epn;
    logic [1:0]        wr_size;
    logic [1:0]        wr_tv;
    logic [RPN_W-1:0]  wr_rpn;
    logic [ATTR_W-1:0] wr_attr;
    logic              inv_en;
    logic [6:0]        inv_idx;
    logic              inv_all;
    logic              rs_valid, rs_hit, rs_miss, rs_multi;
    logic [RA_W-1:0]   rs_ra;
    logic [ATTR_W-1:0] rs_attr;

    xlat_buf dut (.*);

    // Behavioural model of the table
    logic [EPN_W-1:0]  m_epn  [N];
    logic [1:0]        m_sz   [N];
    logic [1:0]        m_tv   [N];
    logic [RPN_W-1:0]  m_rpn  [N];
    logic [ATTR_W-1:0] m_attr [N];

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    function automatic int size_bits(logic [1:0] s);
        if (s == 2'd1) return 16;
        if (s == 2'd2) return 26;
        return 12;
    endfunction

    task automatic clear_inputs();
        lk_valid = 0; lk_tid = 0; lk_ea = '0;
        wr_en = 0; wr_idx = '0; wr_epn = '0; wr_size = '0; wr_tv = '0;
        wr_rpn = '0; wr_attr = '0;
        inv_en = 0; inv_idx = '0; inv_all = 0;
    endtask

    // One clock: expectation from model, model update, compare after edge.
    task automatic tick();
        logic              e_v, e_h, e_m, e_x;
        logic [RA_W-1:0]   e_ra;
        logic [ATTR_W-1:0] e_at;
        int                nhit;
        e_v = 0; e_h = 0; e_m = 0; e_x = 0; e_ra = '0; e_at = '0; nhit = 0;
        if (!rst && lk_valid) begin
            e_v = 1;
            for (int i = 0; i < N; i++) begin
                int sh;
                logic [63:0] page;
                sh   = size_bits(m_sz[i]);
                page = {m_epn[i], 12'h000};
                if (m_tv[i][lk_tid] && m_sz[i] != 2'd3 && ((lk_ea >> sh) == (page >> sh))) begin
                    logic [63:0] full;
                    logic [63:0] omask;
                    nhit++;
                    full  = {16'h0, m_rpn[i], 12'h000};
                    omask = (64'd1 << sh) - 64'd1;
                    full  = (full & ~omask) | (lk_ea & omask);
                    e_ra  = full[RA_W-1:0];
                    e_at  = m_attr[i];
                end
            end
            e_h = (nhit > 0);
            e_m = (nhit == 0);
            e_x = (nhit > 1);
            if (nhit != 1) begin e_ra = '0; e_at = '0; end
        end
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_tv[i] = '0; m_epn[i] = '0; m_sz[i] = '0; m_rpn[i] = '0; m_attr[i] = '0;
            end
        end else if (inv_all) begin
            for (int i = 0; i < N; i++) m_tv[i] = '0;
        end else begin
            if (wr_en) begin
                m_epn[wr_idx] = wr_epn; m_sz[wr_idx] = wr_size; m_tv[wr_idx] = wr_tv;
                m_rpn[wr_idx] = wr_rpn; m_attr[wr_idx] = wr_attr;
            end
            if (inv_en) m_tv[inv_idx] = '0;
        end
        @(negedge clk);
        checks++;
        if (rs_valid !== e_v || rs_hit !== e_h || rs_miss !== e_m || rs_multi !== e_x ||
            rs_ra !== e_ra || rs_attr !== e_at) begin
            fails++;
            $display("FAIL %s: got v%b h%b m%b x%b ra=%h at=%h, expected v%b h%b m%b x%b ra=%h at=%h",
                     cur_req, rs_valid, rs_hit, rs_miss, rs_multi, rs_ra, rs_attr,
                     e_v, e_h, e_m, e_x, e_ra, e_at);
        end
    endtask

    task automatic write_ent(int idx, logic [EPN_W-1:0] epn, logic [1:0] sz,
                             logic [1:0] tv, logic [RPN_W-1:0] rpn, logic [ATTR_W-1:0] at);
        clear_inputs();
        wr_en = 1; wr_idx = 7'(idx); wr_epn = epn; wr_size = sz; wr_tv = tv;
        wr_rpn = rpn; wr_attr = at;
        tick();
    endtask

    task automatic look(logic tid, logic [EA_W-1:0] ea);
        clear_inputs();
        lk_valid = 1; lk_tid = tid; lk_ea = ea;
        tick();
    endtask

    function automatic logic [EA_W-1:0] ea_of(logic [EPN_W-1:0] epn, logic [11:0] off);
        return {epn, off};
    endfunction

    localparam logic [EPN_W-1:0] E_A = 52'hA_1234_5678_9AB0;
    localparam logic [EPN_W-1:0] E_B = 52'hB_2222_3333_4440;
    localparam logic [EPN_W-1:0] E_C = 52'hC_7777_0000_0000;
    localparam logic [EPN_W-1:0] E_D = 52'hD_0101_0101_0100;
    localparam logic [EPN_W-1:0] E_E = 52'hE_5555_6666_7770;

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1;
        cur_req = "R1";
        repeat (3) tick();
        rst = 0;
        clear_inputs();
        tick();                                  // R1: first result after reset is zero
        look(0, 64'h1234_5678_9ABC_DEF0);        // R1: empty table misses
        look(1, ea_of(E_A, 12'h0));

        cur_req = "R12";
        clear_inputs(); tick(); tick();

        // R3: page sizes and ignored bits
        cur_req = "R3";
        write_ent(5,  E_A, 2'd0, 2'b11, 36'h0_00AB_CDE1, 8'h11);
        write_ent(9,  E_B, 2'd1, 2'b11, 36'h0_0123_4560, 8'h22);
        write_ent(20, E_C, 2'd2, 2'b11, 36'h0_0F00_0000, 8'h33);
        write_ent(30, E_D, 2'd3, 2'b11, 36'h0_0000_0001, 8'h44);
        look(0, ea_of(E_A, 12'h5A5));
        look(0, ea_of(E_A ^ 52'h1, 12'h5A5));
        look(1, ea_of(E_B ^ 52'h8, 12'hFFF));
        look(1, ea_of(E_B ^ 52'h10, 12'hFFF));
        look(0, ea_of(E_C ^ 52'h2000, 12'h123));
        look(0, ea_of(E_C ^ 52'h4000, 12'h123));
        look(0, ea_of(E_D, 12'h000));

        // R4: thread qualification
        cur_req = "R4";
        write_ent(40, E_E, 2'd0, 2'b01, 36'h0_0000_4440, 8'h55);
        look(0, ea_of(E_E, 12'h010));
        look(1, ea_of(E_E, 12'h010));

        // R11: attributes
        cur_req = "R11";
        write_ent(41, E_E ^ 52'h100, 2'd1, 2'b10, 36'h0_000F_FFF0, 8'hC3);
        look(1, ea_of(E_E ^ 52'h10F, 12'hABC));

        // R7: multi-hit
        cur_req = "R7";
        write_ent(60, E_A, 2'd1, 2'b10, 36'h0_0000_7770, 8'h77);
        look(1, ea_of(E_A, 12'h0));
        look(0, ea_of(E_A, 12'h0));

        // R8: write and lookup in the same cycle
        cur_req = "R8";
        clear_inputs();
        wr_en = 1; wr_idx = 7'd50; wr_epn = 52'h5_5000_0000_0000; wr_size = 2'd0;
        wr_tv = 2'b11; wr_rpn = 36'h0_0050_0000; wr_attr = 8'h50;
        lk_valid = 1; lk_tid = 0; lk_ea = ea_of(52'h5_5000_0000_0000, 12'h050);
        tick();
        look(0, ea_of(52'h5_5000_0000_0000, 12'h050));
        clear_inputs();
        wr_en = 1; wr_idx = 7'd50; wr_epn = 52'h6_6000_0000_0000; wr_size = 2'd0;
        wr_tv = 2'b11; wr_rpn = 36'h0_0060_0000; wr_attr = 8'h60;
        lk_valid = 1; lk_tid = 1; lk_ea = ea_of(52'h5_5000_0000_0000, 12'h051);
        tick();
        look(1, ea_of(52'h5_5000_0000_0000, 12'h051));

        // R9: single invalidate, beats same-index write
        cur_req = "R9";
        clear_inputs(); inv_en = 1; inv_idx = 7'd5; tick();
        look(0, ea_of(E_A, 12'h5A5));
        clear_inputs();
        inv_en = 1; inv_idx = 7'd9;
        wr_en = 1; wr_idx = 7'd9; wr_epn = E_B; wr_size = 2'd1; wr_tv = 2'b11;
        wr_rpn = 36'h1; wr_attr = 8'h99;
        tick();
        look(0, ea_of(E_B, 12'h0));
        look(0, ea_of(E_C, 12'h0));

        // R5 / R2: many entries, back-to-back random lookups
        cur_req = "R5";
        for (int k = 0; k < 128; k++) begin
            logic [EPN_W-1:0] e;
            e = {20'(k + 1), 32'($urandom)} & ~52'h3FFF;
            write_ent(k, e, 2'(k % 3), 2'(k % 3 + 1), 36'($urandom), 8'($urandom));
        end
        cur_req = "R2";
        for (int k = 0; k < 400; k++) begin
            logic [EA_W-1:0] ea;
            int              pick;
            pick = k % 128;
            ea   = {m_epn[pick], 12'h0} ^ {32'h0, 32'($urandom) & 32'h03FF_FFFF};
            if (k % 7 == 0) ea = {$urandom, $urandom};
            look(1'(k % 2), ea);
        end

        // R10: invalidate all overrides a write
        cur_req = "R10";
        clear_inputs();
        inv_all = 1;
        wr_en = 1; wr_idx = 7'd3; wr_epn = E_A; wr_size = 2'd0; wr_tv = 2'b11;
        wr_rpn = 36'h3; wr_attr = 8'h03;
        tick();
        for (int k = 0; k < 8; k++) look(1'(k % 2), {m_epn[k * 16], 12'h0});
        look(0, ea_of(E_A, 12'h0));

        cur_req = "R12";
        clear_inputs(); tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule